// File: doc/BRIEF.md
# RGB neighbour-pixel similarity checker

This block decides, pixel by pixel, whether a pixel in a 2x2 approximation window can be replaced by that window's representative pixel. The pixels arrive as a stream over a valid/ready handshake. Each pixel is 24 bits wide and holds three 8-bit channels. It comes with its row and column position inside the window and with a 4-bit threshold.

The pixel at window position row 0, column 0 becomes the representative. It is latched in a register. Each other pixel of the window is compared with that stored pixel, not with the pixel before it. Two pixels count as similar when the largest absolute channel difference is no greater than the threshold. A threshold of 0 therefore accepts only identical pixels.

For every accepted pixel, the block registers a result one cycle later. The result carries the verdict and the representative value that a later stage would copy. On the window's last position (row 1, column 1) it also reports whether the whole window can be approximated.

Top module: `pix_sim_top`

## Requirements
- R1: While rst_ni is low, res_valid_o is 0, and it remains 0 on the first cycle after reset is released.
- R2: pix_ready_o equals (not res_valid_o) or res_ready_i. While res_valid_o is 1 and res_ready_i is 0, every result output keeps its value.
- R3: A pixel is accepted at a rising clock edge where pix_valid_i and pix_ready_o are both 1. Its result appears, with res_valid_o at 1, right after that same edge. Without an accepted pixel, a consumed result (res_ready_i at 1) clears res_valid_o.
- R4: An accepted pixel at position row 0, column 0 is stored as the representative. Its result has is_rep_o at 1, similar_o at 1, and rep_o equal to that pixel. The packing is red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R5: For an accepted pixel at any other position, similar_o is 1 exactly when max(|dR|, |dG|, |dB|) against the stored representative is at most thresh_i. In that case rep_o carries the stored representative and is_rep_o is 0.
- R6: Channel differences do not wrap around. Channel values 0 and 255 differ by 255, so they are never similar at any threshold from 0 to 15.
- R7: With thresh_i equal to 0, similar_o is 1 only when the pixel equals the representative in all three channels.
- R8: A pixel is compared with the representative, never with the pixel accepted just before it.
- R9: win_done_o is 1 exactly for the result of a pixel at position row 1, column 1. win_ok_o is 1 only there, and only when all three non-representative pixels since the last representative were similar.
- R10: A pixel that is not accepted changes neither the stored representative nor any result output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_ready_o | output | 1 | Block can accept a pixel |
| pix_r_i | input | 8 | Red channel |
| pix_g_i | input | 8 | Green channel |
| pix_b_i | input | 8 | Blue channel |
| pos_row_i | input | 1 | Row of the pixel inside the 2x2 window |
| pos_col_i | input | 1 | Column of the pixel inside the 2x2 window |
| thresh_i | input | 4 | Similarity threshold, 0 to 15 |
| res_ready_i | input | 1 | Consumer takes the current result |
| res_valid_o | output | 1 | Result valid |
| similar_o | output | 1 | Pixel is similar to the representative |
| is_rep_o | output | 1 | Result belongs to a representative pixel |
| rep_o | output | 24 | Representative value {R,G,B} |
| win_done_o | output | 1 | Result closes a window (position 1,1) |
| win_ok_o | output | 1 | Whole window can be approximated |

## Verification
The properties assume that the window positions of accepted pixels follow the order (0,0), (0,1), (1,0), (1,1). They also assume that the pixel inputs hold steady while pix_valid_i is high and the pixel has not been accepted. The bench presents every window in that order and changes its inputs only away from the active clock edge. When it stalls the consumer, it keeps the pending pixel unchanged. The threshold stays within its 4-bit range by construction.

// File: rtl/pix_sim_pkg.sv
package pix_sim_pkg;
  localparam int unsigned CH_W_DEF = 8;
  localparam int unsigned TH_W_DEF = 4;
  localparam int unsigned NCH_DEF  = 3;

  typedef enum logic [1:0] {
    POS_REP  = 2'b00,
    POS_R0C1 = 2'b01,
    POS_R1C0 = 2'b10,
    POS_LAST = 2'b11
  } win_pos_e;
endpackage

// File: rtl/chan_absdiff.sv
module chan_absdiff #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] abs_o
);
  logic [W:0] diff;
  logic [W:0] neg;

  // one extra bit keeps the sign, so 0-255 cannot wrap
  assign diff  = {1'b0, a_i} - {1'b0, b_i};
  assign neg   = ~diff + 1'b1;
  assign abs_o = diff[W] ? neg[W-1:0] : diff[W-1:0];
endmodule

// File: rtl/pix_sim_cmp.sv
module pix_sim_cmp #(
  parameter int unsigned CH_W = 8,
  parameter int unsigned NCH  = 3,
  parameter int unsigned TH_W = 4,
  localparam int unsigned PIX_W = CH_W * NCH
) (
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] ref_i,
  input  logic [TH_W-1:0]  thresh_i,
  output logic             sim_o
);
  logic [CH_W-1:0] ch_abs [NCH];
  logic [CH_W-1:0] max_abs;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_absdiff #(.W(CH_W)) u_abs (
      .a_i  (pix_i[c*CH_W +: CH_W]),
      .b_i  (ref_i[c*CH_W +: CH_W]),
      .abs_o(ch_abs[c])
    );
  end

  always_comb begin
    max_abs = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_abs[c] > max_abs) max_abs = ch_abs[c];
    end
  end

  assign sim_o = ({{(CH_W){1'b0}}, max_abs} <= {{(CH_W){1'b0}}, {{(CH_W-TH_W){1'b0}}, thresh_i}});
endmodule

// File: rtl/pix_sim_top.sv
module pix_sim_top
  import pix_sim_pkg::*;
#(
  parameter int unsigned CH_W = CH_W_DEF,
  parameter int unsigned TH_W = TH_W_DEF,
  localparam int unsigned PIX_W = CH_W * NCH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  output logic             pix_ready_o,
  input  logic [CH_W-1:0]  pix_r_i,
  input  logic [CH_W-1:0]  pix_g_i,
  input  logic [CH_W-1:0]  pix_b_i,
  input  logic             pos_row_i,
  input  logic             pos_col_i,
  input  logic [TH_W-1:0]  thresh_i,
  input  logic             res_ready_i,
  output logic             res_valid_o,
  output logic             similar_o,
  output logic             is_rep_o,
  output logic [PIX_W-1:0] rep_o,
  output logic             win_done_o,
  output logic             win_ok_o
);
  logic [PIX_W-1:0] pix_in;
  logic [PIX_W-1:0] rep_q;
  logic             acc_q;
  logic             accept;
  logic             cmp_sim;
  win_pos_e         pos;

  assign pix_in      = {pix_r_i, pix_g_i, pix_b_i};
  assign pos         = win_pos_e'({pos_row_i, pos_col_i});
  assign pix_ready_o = ~res_valid_o | res_ready_i;
  assign accept      = pix_valid_i & pix_ready_o;

  pix_sim_cmp #(.CH_W(CH_W), .NCH(NCH_DEF), .TH_W(TH_W)) u_cmp (
    .pix_i   (pix_in),
    .ref_i   (rep_q),
    .thresh_i(thresh_i),
    .sim_o   (cmp_sim)
  );

  // representative and window accumulator
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q <= '0;
      acc_q <= 1'b0;
    end else if (accept) begin
      if (pos == POS_REP) begin
        rep_q <= pix_in;
        acc_q <= 1'b1;
      end else begin
        acc_q <= acc_q & cmp_sim;
      end
    end
  end

  // result register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      similar_o   <= 1'b0;
      is_rep_o    <= 1'b0;
      rep_o       <= '0;
      win_done_o  <= 1'b0;
      win_ok_o    <= 1'b0;
    end else if (accept) begin
      res_valid_o <= 1'b1;
      if (pos == POS_REP) begin
        similar_o  <= 1'b1;
        is_rep_o   <= 1'b1;
        rep_o      <= pix_in;
        win_done_o <= 1'b0;
        win_ok_o   <= 1'b0;
      end else begin
        similar_o  <= cmp_sim;
        is_rep_o   <= 1'b0;
        rep_o      <= rep_q;
        win_done_o <= (pos == POS_LAST);
        win_ok_o   <= (pos == POS_LAST) & acc_q & cmp_sim;
      end
    end else if (res_ready_i) begin
      res_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pix_sim_chk.sv
module pix_sim_chk #(
  parameter int unsigned CH_W  = 8,
  parameter int unsigned TH_W  = 4,
  parameter int unsigned PIX_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_valid_i,
  input logic             pix_ready_o,
  input logic [CH_W-1:0]  pix_r_i,
  input logic [CH_W-1:0]  pix_g_i,
  input logic [CH_W-1:0]  pix_b_i,
  input logic             pos_row_i,
  input logic             pos_col_i,
  input logic [TH_W-1:0]  thresh_i,
  input logic             res_ready_i,
  input logic             res_valid_o,
  input logic             similar_o,
  input logic             is_rep_o,
  input logic [PIX_W-1:0] rep_o,
  input logic             win_done_o,
  input logic             win_ok_o
);
  logic acc;
  assign acc = pix_valid_i & pix_ready_o;

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> res_valid_o);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(rep_o) && $stable(similar_o)
                                       && $stable(win_ok_o) && $stable(is_rep_o)));

  p_no_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> ($stable(rep_o) && $stable(similar_o) && $stable(win_done_o)));

  p_rep_self_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !pos_row_i && !pos_col_i) |=> (is_rep_o && similar_o &&
      rep_o == {$past(pix_r_i), $past(pix_g_i), $past(pix_b_i)}));

  p_thr0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && thresh_i == '0 && (pos_row_i || pos_col_i)) |=>
      (similar_o == ({$past(pix_r_i), $past(pix_g_i), $past(pix_b_i)} == rep_o)));

  p_ok_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && win_ok_o) |-> (win_done_o && similar_o && !is_rep_o));

  p_done_pos_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (win_done_o == ($past(pos_row_i) && $past(pos_col_i))));
endmodule

bind pix_sim_top pix_sim_chk #(.CH_W(CH_W), .TH_W(TH_W), .PIX_W(PIX_W)) u_chk (.*);

// File: tb/pix_sim_top_test.sv
module pix_sim_top_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pix_valid_i = 1'b0;
  logic        pix_ready_o;
  logic [7:0]  pix_r_i = '0, pix_g_i = '0, pix_b_i = '0;
  logic        pos_row_i = 1'b0, pos_col_i = 1'b0;
  logic [3:0]  thresh_i = '0;
  logic        res_ready_i = 1'b1;
  logic        res_valid_o, similar_o, is_rep_o, win_done_o, win_ok_o;
  logic [23:0] rep_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  pix_sim_top uut (.*);

  // {row, col, thr[3:0], pixel[23:0], exp_sim, exp_ok}
  function automatic logic [31:0] v(input logic [1:0] pos, input logic [3:0] thr,
                                    input logic [23:0] p, input logic s, input logic ok);
    return {pos, thr, p, s, ok};
  endfunction

  localparam int NV = 24;
  localparam logic [31:0] VEC [NV] = '{
    // thr 4: channel diff of exactly 4 passes, 5 fails (R5)
    v(2'b00, 4'd4,  24'h0A141E, 1'b1, 1'b0),
    v(2'b01, 4'd4,  24'h0E1022, 1'b1, 1'b0),
    v(2'b10, 4'd4,  24'h0F141E, 1'b0, 1'b0),
    v(2'b11, 4'd4,  24'h0A141E, 1'b1, 1'b0),
    // thr 15: 0 vs 255 must not wrap (R6)
    v(2'b00, 4'd15, 24'h0080FF, 1'b1, 1'b0),
    v(2'b01, 4'd15, 24'h0F71F0, 1'b1, 1'b0),
    v(2'b10, 4'd15, 24'hFF80FF, 1'b0, 1'b0),
    v(2'b11, 4'd15, 24'h008FFF, 1'b1, 1'b0),
    // all similar: window approximable (R9)
    v(2'b00, 4'd15, 24'hC8C8C8, 1'b1, 1'b0),
    v(2'b01, 4'd15, 24'hD2BED7, 1'b1, 1'b0),
    v(2'b10, 4'd15, 24'hD7B9C8, 1'b1, 1'b0),
    v(2'b11, 4'd15, 24'hCDCDCD, 1'b1, 1'b1),
    // similar to predecessor only (R8)
    v(2'b00, 4'd3,  24'h646464, 1'b1, 1'b0),
    v(2'b01, 4'd3,  24'h676464, 1'b1, 1'b0),
    v(2'b10, 4'd3,  24'h6A6464, 1'b0, 1'b0),
    v(2'b11, 4'd3,  24'h646464, 1'b1, 1'b0),
    // thr 0: only identical (R7)
    v(2'b00, 4'd0,  24'h323C46, 1'b1, 1'b0),
    v(2'b01, 4'd0,  24'h323C46, 1'b1, 1'b0),
    v(2'b10, 4'd0,  24'h323C47, 1'b0, 1'b0),
    v(2'b11, 4'd0,  24'h323C46, 1'b1, 1'b0),
    v(2'b00, 4'd0,  24'h01FE7F, 1'b1, 1'b0),
    v(2'b01, 4'd0,  24'h01FE7F, 1'b1, 1'b0),
    v(2'b10, 4'd0,  24'h01FE7F, 1'b1, 1'b0),
    v(2'b11, 4'd0,  24'h01FE7F, 1'b1, 1'b1)
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] vec);
    pix_valid_i = 1'b1;
    {pos_row_i, pos_col_i} = vec[31:30];
    thresh_i = vec[29:26];
    {pix_r_i, pix_g_i, pix_b_i} = vec[25:2];
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [23:0] exp_rep;
    logic [23:0] held;
    exp_rep = '0;
    repeat (2) @(negedge clk_i);
    check("R1 reset", {31'b0, res_valid_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", {31'b0, res_valid_o}, 32'd0);

    drive(VEC[0]);
    for (int i = 0; i < NV; i++) begin
      logic [1:0] pos;
      logic [31:0] act, exp;
      pos = VEC[i][31:30];
      if (pos == 2'b00) exp_rep = VEC[i][25:2];
      @(negedge clk_i);
      act = {res_valid_o, similar_o, is_rep_o, win_done_o, win_ok_o, 3'b0, rep_o};
      exp = {1'b1, VEC[i][1], pos == 2'b00, pos == 2'b11, VEC[i][0], 3'b0, exp_rep};
      check("R3/R4/R5/R6/R7/R8/R9 vector", act, exp);
      if (i + 1 < NV) drive(VEC[i + 1]);
    end

    // stall: pending result must hold, new pixel not taken (R2, R10)
    res_ready_i = 1'b0;
    drive(v(2'b00, 4'd0, 24'hABCDEF, 1'b1, 1'b0));
    @(negedge clk_i);
    check("R2 ready low", {31'b0, pix_ready_o}, 32'd0);
    check("R10 rep unchanged", {8'b0, rep_o}, {8'b0, 24'h01FE7F});
    check("R2 hold", {28'b0, res_valid_o, is_rep_o, win_done_o, win_ok_o}, 32'b1011);

    // consume with no new pixel: valid clears (R3)
    pix_valid_i = 1'b0;
    res_ready_i = 1'b1;
    @(negedge clk_i);
    check("R3 clears", {31'b0, res_valid_o}, 32'd0);
    check("R10 idle rep", {8'b0, rep_o}, {8'b0, 24'h01FE7F});
    check("R2 ready high", {31'b0, pix_ready_o}, 32'd1);

    // single accept one cycle latency (R3) then compare against new rep (R5)
    drive(v(2'b00, 4'd2, 24'h101010, 1'b1, 1'b0));
    @(negedge clk_i);
    check("R3 latency", {31'b0, res_valid_o}, 32'd1);
    check("R4 new rep", {8'b0, rep_o}, {8'b0, 24'h101010});
    drive(v(2'b01, 4'd2, 24'h0E1212, 1'b1, 1'b0));
    @(negedge clk_i);
    check("R5 diff 2 thr 2", {30'b0, similar_o, is_rep_o}, 32'b10);
    held = rep_o;
    pix_valid_i = 1'b0;
    @(negedge clk_i);
    check("R10 no accept", {7'b0, res_valid_o, held}, {7'b0, 1'b0, 24'h101010});

    // asynchronous reset mid-stream (R1)
    drive(v(2'b00, 4'd0, 24'h111111, 1'b1, 1'b0));
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", {31'b0, res_valid_o}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule